// File: doc/BRIEF.md
# Double-Precision Round-and-Pack Unit

This block is the final stage of a double-precision arithmetic datapath. An upstream adder, multiplier or divider hands it a sign, a signed unbiased exponent and a normalised 56-bit significand. That significand holds 53 bits of value, including the leading one, followed by three extra low-order bits that record what lies below the result LSB. The block brings tiny values up to the minimum normal exponent with a sticky right shift. It then rounds in one of four modes, renormalises a rounding carry, and saturates exponents that are too large according to mode and sign. It encodes the result as a 64-bit IEEE 754 word and raises inexact, underflow and overflow flags.

An optional flush mode replaces every value below the normal range with a zero or a smallest subnormal, chosen by mode and sign. An underflow-trap enable makes exact subnormal results report underflow as well. The output is registered by default, so a result appears one clock after its input is accepted; a parameter selects a purely combinational variant. Exact zero inputs, unnormalised significands and NaN handling belong to the surrounding datapath.

Top module: `dp_round_pack`

## Requirements
- R1: Rounding mode encoding: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf. In nearest-even, a nonzero extra-bit field adds 3 plus the result LSB (significand bit 3) to the extended significand, so an exact half rounds to the even neighbour.
- R2: For a nonzero extra-bit field, toward-zero adds nothing. Toward +inf adds 8 only for a positive sign. Toward -inf adds 8 only for a negative sign.
- R3: When the three extra bits are zero the significand is used unchanged and no flag is set.
- R4: A rounding carry above the leading-one position halves the significand and increments the exponent.
- R5: An exponent above +1023 after rounding sets overflow and inexact. Nearest gives signed infinity and toward-zero gives the signed largest finite value (exponent field 0x7FE, all-ones fraction). Toward +inf gives +inf or the largest negative finite value. Toward -inf gives the largest positive finite value or -inf.
- R6: With flush enabled and an input exponent below -1022, the result keeps the input sign and sets underflow and inexact. The magnitude is the smallest subnormal (fraction 1) for toward +inf with a positive sign and for toward -inf with a negative sign, and zero otherwise.
- R7: At input exponent -1023 without flush, if rounding the unshifted significand would carry out, the result is the smallest-normal-exponent value from that rounding. It has the extra bits dropped and raises inexact only.
- R8: Otherwise an exponent below -1022 is raised to -1022 by a right shift that ORs every shifted-out bit into bit 0. Any shift of 56 or more leaves only that sticky bit.
- R9: Underflow is raised when the extra bits are nonzero while the leading bit is clear. With the trap enable set, it is also raised for any result encoded as a subnormal, even an exact one.
- R10: A result with the leading bit set is encoded with exponent field (exponent + 1023) and the leading bit dropped. A result with the leading bit clear is encoded with exponent field 0 and the fraction unchanged.
- R11: With the registered variant, result and flags are zero after reset. Each accepted input appears exactly one clock later with out_valid high, and out_valid is low in the cycle after in_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operand valid |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 13 | Signed unbiased exponent |
| in_sig | input | 56 | Normalised significand with three extra low bits |
| rnd_mode | input | 2 | Rounding mode (R1 encoding) |
| flush_en | input | 1 | Flush below-range values |
| uf_trap_en | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Packed double |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
Directed cases target exact ties in nearest mode. A design that rounds half up instead of to even gives an odd LSB there. Other directed cases cover an all-ones significand that carries into a new exponent, and the exponent just below the normal range, where a missed not-tiny path reports underflow and encodes a subnormal instead of the smallest normal. The overflow and flush results are checked for every mode and sign, because a swapped table entry returns infinity where the largest finite value belongs. Huge negative exponents and exact subnormals with the trap enabled probe shift saturation and the trap-only underflow. Random operands cluster around both exponent boundaries and compare the whole result word and all flags against a bench model.

// File: rtl/dp_rp_pkg.sv
package dp_rp_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_UP   = 2'd2,
      RM_DOWN = 2'd3
   } rmode_e;
endpackage

// File: rtl/dp_rp_rounder.sv
module dp_rp_rounder
   import dp_rp_pkg::*;
#(
   parameter int EXT_W = 56
) (
   input  logic             sign,
   input  logic [EXT_W-1:0] sig,
   input  rmode_e           rm,
   output logic             grs_nz,
   output logic [EXT_W:0]   rounded
);
   localparam int GRS_W = 3;

   logic [EXT_W:0] inc;

   always_comb begin
      grs_nz = |sig[GRS_W-1:0];
      inc    = '0;
      if (grs_nz) begin
         unique case (rm)
            RM_NEAR: inc = (EXT_W+1)'(3) + (EXT_W+1)'(sig[GRS_W]);
            RM_ZERO: inc = '0;
            RM_UP:   inc = sign ? '0 : (EXT_W+1)'(8);
            RM_DOWN: inc = sign ? (EXT_W+1)'(8) : '0;
            default: inc = '0;
         endcase
      end
      rounded = {1'b0, sig} + inc;
   end

   // R3: nothing is added when the extra bits are all zero
   always_comb begin
      if (!grs_nz) begin
         p_exact_hold_r3: assert (rounded == {1'b0, sig});
      end
   end
endmodule

// File: rtl/dp_rp_prealign.sv
module dp_rp_prealign
   import dp_rp_pkg::*;
#(
   parameter int EXT_W  = 56,
   parameter int EXP_W  = 13,
   parameter int EXPF_W = 11,
   parameter int FRAC_W = 52
) (
   input  logic                     sign,
   input  logic signed [EXP_W-1:0]  exp_in,
   input  logic [EXT_W-1:0]         sig_in,
   input  rmode_e                   rm,
   input  logic                     flush_en,
   output logic                     flush_hit,
   output logic [EXPF_W+FRAC_W:0]   flush_word,
   output logic                     notiny_hit,
   output logic signed [EXP_W:0]    exp_out,
   output logic [EXT_W-1:0]         sig_out
);
   localparam int XW   = EXP_W + 1;
   localparam int BIAS = (1 << (EXPF_W - 1)) - 1;
   localparam logic signed [XW-1:0] EMIN_X = XW'(1 - BIAS);

   logic signed [XW-1:0] xe;
   logic signed [XW-1:0] shamt;
   logic                 below;
   logic                 boundary;
   logic                 pre_nz;
   logic [EXT_W:0]       pre_rnd;
   logic [EXT_W-1:0]     sig_sh;
   logic [EXT_W-1:0]     lost_mask;
   logic                 tiny_mag;

   dp_rp_rounder #(.EXT_W(EXT_W)) u_pre_rnd (
      .sign    (sign),
      .sig     (sig_in),
      .rm      (rm),
      .grs_nz  (pre_nz),
      .rounded (pre_rnd)
   );

   always_comb begin
      xe        = XW'(exp_in);
      below     = xe < EMIN_X;
      shamt     = EMIN_X - xe;
      boundary  = (xe == EMIN_X - XW'(1)) && pre_rnd[EXT_W];
      lost_mask = '0;
      if (shamt >= XW'(EXT_W)) begin
         sig_sh = {{(EXT_W-1){1'b0}}, |sig_in};
      end else begin
         lost_mask = ~({EXT_W{1'b1}} << shamt);
         sig_sh    = (sig_in >> shamt);
         sig_sh[0] = sig_sh[0] | (|(sig_in & lost_mask));
      end

      tiny_mag   = ((rm == RM_UP) && !sign) || ((rm == RM_DOWN) && sign);
      flush_hit  = below && flush_en;
      flush_word = {sign, {EXPF_W{1'b0}}, {(FRAC_W-1){1'b0}}, tiny_mag};
      notiny_hit = below && !flush_en && boundary;

      exp_out = xe;
      sig_out = sig_in;
      if (below && !flush_en) begin
         exp_out = EMIN_X;
         if (boundary) begin
            sig_out = pre_rnd[EXT_W:1] & ~EXT_W'(7);
         end else begin
            sig_out = sig_sh;
         end
      end
   end

   // R8: a sticky-shifted operand always lands below the leading-one position
   always_comb begin
      if (below && !flush_en && !boundary) begin
         p_shift_tiny_r8: assert (!sig_sh[EXT_W-1]);
      end
   end
endmodule

// File: rtl/dp_rp_packer.sv
module dp_rp_packer
   import dp_rp_pkg::*;
#(
   parameter int EXP_W  = 13,
   parameter int EXPF_W = 11,
   parameter int FRAC_W = 52
) (
   input  logic                     sign,
   input  logic signed [EXP_W:0]    exp_in,
   input  logic [FRAC_W:0]          man,
   input  rmode_e                   rm,
   input  logic                     trap_en,
   output logic [EXPF_W+FRAC_W:0]   word,
   output logic                     ovf,
   output logic                     uf_sub
);
   localparam int XW   = EXP_W + 1;
   localparam int BIAS = (1 << (EXPF_W - 1)) - 1;
   localparam logic signed [XW-1:0] EMAX_X = XW'(BIAS);

   logic           use_inf;
   logic [XW-1:0]  biased;

   always_comb begin
      ovf     = exp_in > EMAX_X;
      use_inf = (rm == RM_NEAR) || ((rm == RM_UP) && !sign) ||
                ((rm == RM_DOWN) && sign);
      biased  = exp_in + XW'(BIAS);
      uf_sub  = 1'b0;
      if (ovf) begin
         word = use_inf ? {sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}}
                        : {sign, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      end else if (!man[FRAC_W]) begin
         uf_sub = trap_en;
         word   = {sign, {EXPF_W{1'b0}}, man[FRAC_W-1:0]};
      end else begin
         word = {sign, biased[EXPF_W-1:0], man[FRAC_W-1:0]};
      end
   end
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack
   import dp_rp_pkg::*;
#(
   parameter int EXP_W      = 13,
   parameter int EXPF_W     = 11,
   parameter int FRAC_W     = 52,
   parameter bit PIPE_STAGE = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic                            in_sign,
   input  logic signed [EXP_W-1:0]         in_exp,
   input  logic [FRAC_W+3:0]               in_sig,
   input  logic [1:0]                      rnd_mode,
   input  logic                            flush_en,
   input  logic                            uf_trap_en,
   output logic                            out_valid,
   output logic [EXPF_W+FRAC_W:0]          out_result,
   output logic                            out_inexact,
   output logic                            out_underflow,
   output logic                            out_overflow
);
   localparam int GRS_W = 3;
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXT_W = SIG_W + GRS_W;
   localparam int TOT_W = EXPF_W + FRAC_W + 1;
   localparam int XW    = EXP_W + 1;

   if (EXP_W < EXPF_W + 2) begin : g_bad_exp
      $error("dp_round_pack: EXP_W too narrow for the exponent range");
   end
   if (EXPF_W < 2 || FRAC_W < 2) begin : g_bad_fmt
      $error("dp_round_pack: format fields too small");
   end

   rmode_e               rm;
   logic                 flush_hit;
   logic [TOT_W-1:0]     flush_word;
   logic                 notiny_hit;
   logic signed [XW-1:0] al_exp;
   logic [EXT_W-1:0]     al_sig;
   logic                 grs_nz;
   logic [EXT_W:0]       rnd_sig;
   logic [EXT_W-1:0]     norm_sig;
   logic signed [XW-1:0] norm_exp;
   logic [TOT_W-1:0]     pk_word;
   logic                 pk_ovf;
   logic                 pk_uf_sub;
   logic [TOT_W-1:0]     nx_result;
   logic                 nx_inexact;
   logic                 nx_underflow;
   logic                 nx_overflow;

   assign rm = rmode_e'(rnd_mode);

   dp_rp_prealign #(
      .EXT_W (EXT_W),
      .EXP_W (EXP_W),
      .EXPF_W(EXPF_W),
      .FRAC_W(FRAC_W)
   ) u_prealign (
      .sign      (in_sign),
      .exp_in    (in_exp),
      .sig_in    (in_sig),
      .rm        (rm),
      .flush_en  (flush_en),
      .flush_hit (flush_hit),
      .flush_word(flush_word),
      .notiny_hit(notiny_hit),
      .exp_out   (al_exp),
      .sig_out   (al_sig)
   );

   dp_rp_rounder #(.EXT_W(EXT_W)) u_rounder (
      .sign   (in_sign),
      .sig    (al_sig),
      .rm     (rm),
      .grs_nz (grs_nz),
      .rounded(rnd_sig)
   );

   always_comb begin
      norm_sig = al_sig;
      norm_exp = al_exp;
      if (grs_nz) begin
         if (rnd_sig[EXT_W]) begin
            norm_sig = rnd_sig[EXT_W:1];
            norm_exp = al_exp + XW'(1);
         end else begin
            norm_sig = rnd_sig[EXT_W-1:0];
         end
      end
   end

   dp_rp_packer #(
      .EXP_W (EXP_W),
      .EXPF_W(EXPF_W),
      .FRAC_W(FRAC_W)
   ) u_packer (
      .sign   (in_sign),
      .exp_in (norm_exp),
      .man    (norm_sig[EXT_W-1:GRS_W]),
      .rm     (rm),
      .trap_en(uf_trap_en),
      .word   (pk_word),
      .ovf    (pk_ovf),
      .uf_sub (pk_uf_sub)
   );

   always_comb begin
      if (flush_hit) begin
         nx_result    = flush_word;
         nx_inexact   = 1'b1;
         nx_underflow = 1'b1;
         nx_overflow  = 1'b0;
      end else begin
         nx_result    = pk_word;
         nx_overflow  = pk_ovf;
         nx_inexact   = grs_nz || notiny_hit || pk_ovf;
         nx_underflow = (grs_nz && !al_sig[EXT_W-1]) || pk_uf_sub;
      end
   end

   if (PIPE_STAGE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid     <= 1'b0;
            out_result    <= '0;
            out_inexact   <= 1'b0;
            out_underflow <= 1'b0;
            out_overflow  <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_result    <= nx_result;
               out_inexact   <= nx_inexact;
               out_underflow <= nx_underflow;
               out_overflow  <= nx_overflow;
            end
         end
      end

      // R11: one-cycle latency on the valid path
      p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_idle_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
   end else begin : g_comb
      assign out_valid     = in_valid;
      assign out_result    = nx_result;
      assign out_inexact   = nx_inexact;
      assign out_underflow = nx_underflow;
      assign out_overflow  = nx_overflow;
   end

   // R5: saturation always reports inexact and lands on the top exponent codes
   p_ovf_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_overflow) |-> (out_inexact && !out_underflow));
   p_ovf_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_overflow) |->
      (out_result[TOT_W-2 -: EXPF_W] >= {{(EXPF_W-1){1'b1}}, 1'b0}));
   // R9: underflow only accompanies the two lowest exponent codes
   p_uf_expfield_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_underflow) |->
      (out_result[TOT_W-2 -: EXPF_W] <= EXPF_W'(1)));
endmodule

// File: tb/dp_round_pack_bench.sv
`timescale 1ns/1ps
module dp_round_pack_bench;
   localparam realtime CLK_HALF = 5ns;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               in_sign = 1'b0;
   logic signed [12:0] in_exp = '0;
   logic [55:0]        in_sig = 56'h80_0000_0000_0000;
   logic [1:0]         rnd_mode = 2'd0;
   logic               flush_en = 1'b0;
   logic               uf_trap_en = 1'b0;
   logic               out_valid;
   logic [63:0]        out_result;
   logic               out_inexact;
   logic               out_underflow;
   logic               out_overflow;

   int checks = 0;
   int errors = 0;

   always #(CLK_HALF) clk = ~clk;

   dp_round_pack u_dp_round_pack (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_sign      (in_sign),
      .in_exp       (in_exp),
      .in_sig       (in_sig),
      .rnd_mode     (rnd_mode),
      .flush_en     (flush_en),
      .uf_trap_en   (uf_trap_en),
      .out_valid    (out_valid),
      .out_result   (out_result),
      .out_inexact  (out_inexact),
      .out_underflow(out_underflow),
      .out_overflow (out_overflow)
   );

   function automatic logic [63:0] apply_mode(bit s, logic [63:0] m, bit [1:0] rm);
      logic [63:0] r = m;
      if (m[2:0] != 3'd0) begin
         case (rm)
            2'd0: r = m + 64'd3 + {63'd0, m[3]};
            2'd1: r = m;
            2'd2: r = s ? m : m + 64'd8;
            default: r = s ? m + 64'd8 : m;
         endcase
      end
      return r;
   endfunction

   task automatic ref_model(input bit s, input int e_in, input logic [55:0] m_in,
                            input bit [1:0] rm, input bit fl, input bit tr,
                            output logic [63:0] r, output bit ix,
                            output bit uf, output bit of);
      logic [63:0] m = {8'd0, m_in};
      logic [63:0] t;
      int e = e_in;
      bit done = 0;
      ix = 0; uf = 0; of = 0; r = '0;
      if (e < -1022) begin
         if (fl) begin
            uf = 1; ix = 1;
            r = {s, 63'd0};
            if ((rm == 2'd2 && !s) || (rm == 2'd3 && s)) r[0] = 1'b1;
            done = 1;
         end else begin
            t = apply_mode(s, m, rm);
            if (e == -1023 && t[56]) begin
               ix = 1;
               m = (t >> 1) & ~64'h7;
            end else begin
               for (int k = 0; k < -1022 - e && k < 60; k++) begin
                  m = {1'b0, m[63:1]} | {63'd0, m[0]};
               end
            end
            e = -1022;
         end
      end
      if (!done) begin
         if (m[2:0] != 3'd0) begin
            ix = 1;
            if (!m[55]) uf = 1;
            m = apply_mode(s, m, rm);
            if (m[56]) begin
               m = m >> 1;
               e = e + 1;
            end
         end
         m = m >> 3;
         if (e > 1023) begin
            of = 1; ix = 1;
            if (rm == 2'd0 || (rm == 2'd2 && !s) || (rm == 2'd3 && s))
               r = {s, 11'h7FF, 52'd0};
            else
               r = {s, 11'h7FE, {52{1'b1}}};
         end else if (!m[52]) begin
            if (tr) uf = 1;
            r = {s, 11'd0, m[51:0]};
         end else begin
            r = {s, 11'(e + 1023), m[51:0]};
         end
      end
   endtask

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h expected=%h", req, got, exp);
      end
   endtask

   // drive one operand, compare against the model one clock later
   task automatic run_case(input string req, input bit s, input int e,
                           input logic [55:0] m, input bit [1:0] rm,
                           input bit fl, input bit tr);
      logic [63:0] r;
      bit ix, uf, of;
      ref_model(s, e, m, rm, fl, tr, r, ix, uf, of);
      @(negedge clk);
      in_valid = 1'b1; in_sign = s; in_exp = 13'(e); in_sig = m;
      rnd_mode = rm; flush_en = fl; uf_trap_en = tr;
      @(negedge clk);
      chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
      chk({req, " result"}, out_result, r);
      chk({req, " flags"}, {61'd0, out_inexact, out_underflow, out_overflow},
          {61'd0, ix, uf, of});
   endtask

   task automatic run_fixed(input string req, input bit s, input int e,
                            input logic [55:0] m, input bit [1:0] rm,
                            input bit fl, input bit tr,
                            input logic [63:0] exp_r, input bit [2:0] exp_f);
      @(negedge clk);
      in_valid = 1'b1; in_sign = s; in_exp = 13'(e); in_sig = m;
      rnd_mode = rm; flush_en = fl; uf_trap_en = tr;
      @(negedge clk);
      chk({req, " result"}, out_result, exp_r);
      chk({req, " flags ix/uf/of"},
          {61'd0, out_inexact, out_underflow, out_overflow}, {61'd0, exp_f});
   endtask

   localparam logic [55:0] ONE  = 56'h80_0000_0000_0000;
   localparam logic [55:0] ALL1 = 56'hFF_FFFF_FFFF_FFFF;

   initial begin : watchdog
      #(2_000_000ns);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset valid", {63'd0, out_valid}, 64'd0);
      chk("R11 reset result", out_result, 64'd0);
      chk("R11 reset flags", {61'd0, out_inexact, out_underflow, out_overflow}, 64'd0);
      rst_n = 1'b1;

      run_fixed("R3 R10 exact one", 0, 0, ONE, 2'd0, 0, 0, 64'h3FF0_0000_0000_0000, 3'b000);
      run_fixed("R1 tie even", 0, 0, ONE | 56'h4, 2'd0, 0, 0, 64'h3FF0_0000_0000_0000, 3'b100);
      run_fixed("R1 tie odd", 0, 0, ONE | 56'hC, 2'd0, 0, 0, 64'h3FF0_0000_0000_0002, 3'b100);
      run_fixed("R2 toward zero", 0, 0, ONE | 56'h7, 2'd1, 0, 0, 64'h3FF0_0000_0000_0000, 3'b100);
      run_fixed("R2 up positive", 0, 0, ONE | 56'h1, 2'd2, 0, 0, 64'h3FF0_0000_0000_0001, 3'b100);
      run_fixed("R2 up negative", 1, 0, ONE | 56'h1, 2'd2, 0, 0, 64'hBFF0_0000_0000_0000, 3'b100);
      run_fixed("R2 down negative", 1, 0, ONE | 56'h1, 2'd3, 0, 0, 64'hBFF0_0000_0000_0001, 3'b100);
      run_fixed("R4 carry out", 0, 0, ALL1, 2'd0, 0, 0, 64'h4000_0000_0000_0000, 3'b100);
      run_fixed("R10 largest finite", 1, 1023, ALL1, 2'd1, 0, 0, 64'hFFEF_FFFF_FFFF_FFFF, 3'b100);
      run_fixed("R5 near carry", 0, 1023, ALL1, 2'd0, 0, 0, 64'h7FF0_0000_0000_0000, 3'b101);
      run_fixed("R5 zero neg", 1, 1024, ONE, 2'd1, 0, 0, 64'hFFEF_FFFF_FFFF_FFFF, 3'b101);
      run_fixed("R5 up pos", 0, 1024, ONE, 2'd2, 0, 0, 64'h7FF0_0000_0000_0000, 3'b101);
      run_fixed("R5 up neg", 1, 1024, ONE, 2'd2, 0, 0, 64'hFFEF_FFFF_FFFF_FFFF, 3'b101);
      run_fixed("R5 down pos", 0, 1024, ONE, 2'd3, 0, 0, 64'h7FEF_FFFF_FFFF_FFFF, 3'b101);
      run_fixed("R5 down neg", 1, 1024, ONE, 2'd3, 0, 0, 64'hFFF0_0000_0000_0000, 3'b101);
      run_fixed("R6 flush near neg", 1, -1023, ONE, 2'd0, 1, 0, 64'h8000_0000_0000_0000, 3'b110);
      run_fixed("R6 flush up pos", 0, -1023, ONE, 2'd2, 1, 0, 64'h0000_0000_0000_0001, 3'b110);
      run_fixed("R6 flush up neg", 1, -1023, ONE, 2'd2, 1, 0, 64'h8000_0000_0000_0000, 3'b110);
      run_fixed("R6 flush down pos", 0, -1023, ONE, 2'd3, 1, 0, 64'h0000_0000_0000_0000, 3'b110);
      run_fixed("R6 flush down neg", 1, -1023, ONE, 2'd3, 1, 0, 64'h8000_0000_0000_0001, 3'b110);
      run_fixed("R7 not tiny", 0, -1023, ALL1, 2'd0, 0, 0, 64'h0010_0000_0000_0000, 3'b100);
      run_fixed("R9 exact sub trap", 0, -1023, ONE, 2'd0, 0, 1, 64'h0008_0000_0000_0000, 3'b010);
      run_fixed("R9 R10 exact sub no trap", 0, -1023, ONE, 2'd0, 0, 0, 64'h0008_0000_0000_0000, 3'b000);
      run_fixed("R8 huge shift up", 0, -4000, ONE, 2'd2, 0, 0, 64'h0000_0000_0000_0001, 3'b110);
      run_fixed("R8 huge shift near", 1, -4000, ONE, 2'd0, 0, 0, 64'h8000_0000_0000_0000, 3'b110);
      run_fixed("R8 sticky 3", 0, -1025, ONE | 56'h1, 2'd1, 0, 0, 64'h0002_0000_0000_0000, 3'b110);

      for (int i = 0; i < 400; i++) begin
         logic [55:0] m;
         int e;
         m = {1'b1, 23'($urandom), $urandom};
         if ($urandom % 4 == 0) m[2:0] = 3'd0;
         if ($urandom % 8 == 0) m = ALL1;
         case ($urandom % 6)
            0: e = -1024 + int'($urandom % 3);
            1: e = -1080 + int'($urandom % 80);
            2: e = 1020 + int'($urandom % 6);
            3: e = -50 + int'($urandom % 100);
            4: e = -4096 + int'($urandom % 3000);
            default: e = int'($urandom % 4096) - 2048;
         endcase
         run_case("R1 R2 R4 R8 R9 random", 1'($urandom), e, m, 2'($urandom),
                  ($urandom % 4) == 0, 1'($urandom));
      end

      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R11 idle valid low", {63'd0, out_valid}, 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule